// File: doc/BRIEF.md
# Winograd 2x2-from-3x3 Convolution Engine

This processing element computes 3x3 convolution with the Winograd minimal-filtering method F(2x2,3x3). Each accepted beat carries a 4x4 tile of input pixels and a 4x4 tile of kernel values that were transformed before they reached the block. The input tile is transformed using additions and subtractions only. It is then multiplied element by element with the kernel tile, which takes sixteen multipliers where direct convolution of the same 2x2 output would take thirty-six. An output transform reduces the products to a 2x2 result tile. Input tiles are taken with stride 2, so neighbouring tiles share two rows and two columns.

Results for one output position are summed over successive input channels in a tile-wide accumulator, with no adder tree. A first-channel flag restarts the sum. A last-channel flag releases the finished tile on a valid/ready output, so a pooling stage can consume it directly while convolution continues. The datapath has six register stages followed by the accumulator. When the pipeline is full it accepts one tile per cycle. A stall on the output freezes every stage at once.

Top module: `wino_conv_pe`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.
- R2: The kernel input tile is the transformed filter U = G·g·G^T scaled by 2^KFRAC (KFRAC=2, so it is 4·G·g·G^T, with G rows [1,0,0], [1/2,1/2,1/2], [1/2,-1/2,1/2], [0,0,1]). Tile element (r,c) sits in bits [(r*4+c)*DW +: DW] and output element (i,j) sits in bits [(i*2+j)*DW +: DW], all as two's-complement values. For a tile flagged both first and last, each output element equals sum over a,b of d[i+a][j+b]·g[a][b], reduced modulo 2^DW.
- R3: A tile flagged first replaces the accumulated sum. Later tiles add their 2x2 result to it. The tile flagged last emits the running sum, and all sums wrap modulo 2^DW.
- R4: With out_ready held high and the pipeline empty, out_valid rises after the seventh rising edge, counting the edge that accepts the last-channel tile as the first.
- R5: While out_ready is high, in_ready is high, so one tile is accepted in every cycle.
- R6: While out_valid is high and out_ready is low, in_ready is low, and on the next cycle out_valid stays high with out_tile unchanged.
- R7: Output tiles appear in acceptance order, and there is exactly one output tile for each accepted last-flagged tile, with none dropped or repeated.
- R8: Cycles with in_valid low and tiles without the last flag produce no output beat and do not alter the accumulated sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input tile present |
| in_ready | output | 1 | Input tile accepted when both valid and ready are high |
| in_tile | input | 16*DW | 4x4 input pixel tile, row-major |
| in_kern | input | 16*DW | 4x4 transformed kernel tile, row-major, KFRAC fractional bits |
| in_first | input | 1 | Tile is the first channel of an output position |
| in_last | input | 1 | Tile is the last channel of an output position |
| out_valid | output | 1 | Accumulated output tile present |
| out_ready | input | 1 | Downstream accepts the output tile |
| out_tile | output | 4*DW | 2x2 accumulated output tile, row-major |

## Verification
Single-channel tiles with random pixels and filters compare the transform chain against direct 3x3 convolution computed in the bench. This separates sign or ordering errors in either transform from errors in the product scaling. Multi-channel groups of random length with idle gaps and random output stalls test the restart and accumulate logic, the no-drop and no-duplicate rule, and ordering. Large directed values force wraparound of the 32-bit sums, which an accumulator with the wrong width or the wrong truncation point would get wrong. Directed runs measure the latency on an empty pipeline, accept tiles back to back with the output always ready, and confirm that a non-final channel emits nothing.

// File: rtl/wino_pkg.sv
package wino_pkg;
    localparam int TIN  = 4;
    localparam int TOUT = 2;
    localparam int NIN  = TIN * TIN;
    localparam int NOUT = TOUT * TOUT;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } ctl_t;
endpackage

// File: rtl/wino_in_xform.sv
module wino_in_xform
    import wino_pkg::*;
#(
    parameter int W  = 32,
    parameter int VW = W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  ctl_t             ctl_i,
    input  logic [NIN*W-1:0] d_i,
    input  logic [NIN*W-1:0] k_i,
    output ctl_t             ctl_o,
    output logic [NIN*VW-1:0] v_o,
    output logic [NIN*W-1:0] k_o
);
    localparam int RW = W + 1;

    typedef struct packed {
        ctl_t              c1;
        logic [NIN*W-1:0]  d1;
        logic [NIN*W-1:0]  k1;
        ctl_t              c2;
        logic [NIN*RW-1:0] r2;
        logic [NIN*W-1:0]  k2;
        ctl_t              c3;
        logic [NIN*VW-1:0] v3;
        logic [NIN*W-1:0]  k3;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        logic signed [RW-1:0] a [TIN];
        logic signed [VW-1:0] b [TIN];
        a   = '{default: '0};
        b   = '{default: '0};
        s_d = s_q;
        if (en) begin
            // stage 1: capture
            s_d.c1 = ctl_i;
            s_d.d1 = d_i;
            s_d.k1 = k_i;
            // stage 2: left transform over rows
            s_d.c2 = s_q.c1;
            s_d.k2 = s_q.k1;
            for (int c = 0; c < TIN; c++) begin
                for (int r = 0; r < TIN; r++) begin
                    a[r] = RW'($signed(s_q.d1[(r*TIN+c)*W +: W]));
                end
                s_d.r2[(0*TIN+c)*RW +: RW] = a[0] - a[2];
                s_d.r2[(1*TIN+c)*RW +: RW] = a[1] + a[2];
                s_d.r2[(2*TIN+c)*RW +: RW] = a[2] - a[1];
                s_d.r2[(3*TIN+c)*RW +: RW] = a[1] - a[3];
            end
            // stage 3: right transform over columns
            s_d.c3 = s_q.c2;
            s_d.k3 = s_q.k2;
            for (int r = 0; r < TIN; r++) begin
                for (int c = 0; c < TIN; c++) begin
                    b[c] = VW'($signed(s_q.r2[(r*TIN+c)*RW +: RW]));
                end
                s_d.v3[(r*TIN+0)*VW +: VW] = b[0] - b[2];
                s_d.v3[(r*TIN+1)*VW +: VW] = b[1] + b[2];
                s_d.v3[(r*TIN+2)*VW +: VW] = b[2] - b[1];
                s_d.v3[(r*TIN+3)*VW +: VW] = b[1] - b[3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.c3;
    assign v_o   = s_q.v3;
    assign k_o   = s_q.k3;
endmodule

// File: rtl/wino_mul.sv
module wino_mul
    import wino_pkg::*;
#(
    parameter int W  = 32,
    parameter int VW = W + 2,
    parameter int PW = VW + W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  ctl_t              ctl_i,
    input  logic [NIN*VW-1:0] v_i,
    input  logic [NIN*W-1:0]  k_i,
    output ctl_t              ctl_o,
    output logic [NIN*PW-1:0] p_o
);
    typedef struct packed {
        ctl_t              c4;
        logic [NIN*PW-1:0] p4;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        logic signed [PW-1:0] sa;
        logic signed [PW-1:0] sb;
        sa  = '0;
        sb  = '0;
        s_d = s_q;
        if (en) begin
            s_d.c4 = ctl_i;
            for (int i = 0; i < NIN; i++) begin
                sa = PW'($signed(v_i[i*VW +: VW]));
                sb = PW'($signed(k_i[i*W +: W]));
                s_d.p4[i*PW +: PW] = sa * sb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.c4;
    assign p_o   = s_q.p4;
endmodule

// File: rtl/wino_out_xform.sv
module wino_out_xform
    import wino_pkg::*;
#(
    parameter int W     = 32,
    parameter int PW    = 66,
    parameter int KFRAC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  ctl_t              ctl_i,
    input  logic [NIN*PW-1:0] p_i,
    output ctl_t              ctl_o,
    output logic [NOUT*W-1:0] y_o
);
    localparam int TW = PW + 2;
    localparam int OW = TW + 2;
    localparam int NT = TOUT * TIN;

    typedef struct packed {
        ctl_t              c5;
        logic [NT*TW-1:0]  t5;
        ctl_t              c6;
        logic [NOUT*W-1:0] y6;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        logic signed [TW-1:0] m [TIN];
        logic signed [OW-1:0] n [TIN];
        logic signed [OW-1:0] y0;
        logic signed [OW-1:0] y1;
        m   = '{default: '0};
        n   = '{default: '0};
        y0  = '0;
        y1  = '0;
        s_d = s_q;
        if (en) begin
            // stage 5: left output transform
            s_d.c5 = ctl_i;
            for (int c = 0; c < TIN; c++) begin
                for (int r = 0; r < TIN; r++) begin
                    m[r] = TW'($signed(p_i[(r*TIN+c)*PW +: PW]));
                end
                s_d.t5[(0*TIN+c)*TW +: TW] = m[0] + m[1] + m[2];
                s_d.t5[(1*TIN+c)*TW +: TW] = m[1] - m[2] - m[3];
            end
            // stage 6: right output transform and rescale
            s_d.c6 = s_q.c5;
            for (int r = 0; r < TOUT; r++) begin
                for (int c = 0; c < TIN; c++) begin
                    n[c] = OW'($signed(s_q.t5[(r*TIN+c)*TW +: TW]));
                end
                y0 = n[0] + n[1] + n[2];
                y1 = n[1] - n[2] - n[3];
                s_d.y6[(r*TOUT+0)*W +: W] = W'(y0 >>> KFRAC);
                s_d.y6[(r*TOUT+1)*W +: W] = W'(y1 >>> KFRAC);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.c6;
    assign y_o   = s_q.y6;
endmodule

// File: rtl/wino_accum.sv
module wino_accum
    import wino_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  ctl_t              ctl_i,
    input  logic [NOUT*W-1:0] y_i,
    output logic              out_valid,
    output logic [NOUT*W-1:0] out_tile
);
    typedef struct packed {
        logic [NOUT*W-1:0] acc;
        logic              ov;
        logic [NOUT*W-1:0] ot;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        logic [NOUT*W-1:0] sum;
        sum = '0;
        s_d = s_q;
        if (en) begin
            s_d.ov = 1'b0;
            if (ctl_i.valid) begin
                for (int i = 0; i < NOUT; i++) begin
                    sum[i*W +: W] = (ctl_i.first ? W'(0) : s_q.acc[i*W +: W])
                                    + y_i[i*W +: W];
                end
                s_d.acc = sum;
                if (ctl_i.last) begin
                    s_d.ov = 1'b1;
                    s_d.ot = sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ov;
    assign out_tile  = s_q.ot;
endmodule

// File: rtl/wino_conv_pe.sv
module wino_conv_pe
    import wino_pkg::*;
#(
    parameter int DW    = 32,
    parameter int KFRAC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [NIN*DW-1:0]  in_tile,
    input  logic [NIN*DW-1:0]  in_kern,
    input  logic               in_first,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [NOUT*DW-1:0] out_tile
);
    localparam int VW = DW + 2;
    localparam int PW = VW + DW;

    logic              advance;
    ctl_t              ctl_in, ctl_v, ctl_p, ctl_y;
    logic [NIN*VW-1:0] v_w;
    logic [NIN*DW-1:0] k_w;
    logic [NIN*PW-1:0] p_w;
    logic [NOUT*DW-1:0] y_w;

    assign advance  = !(out_valid && !out_ready);
    assign in_ready = advance;
    assign ctl_in   = '{valid: in_valid, first: in_first, last: in_last};

    wino_in_xform #(.W(DW), .VW(VW)) u_inx (
        .clk(clk), .rst_n(rst_n), .en(advance), .ctl_i(ctl_in),
        .d_i(in_tile), .k_i(in_kern), .ctl_o(ctl_v), .v_o(v_w), .k_o(k_w)
    );

    wino_mul #(.W(DW), .VW(VW), .PW(PW)) u_mul (
        .clk(clk), .rst_n(rst_n), .en(advance), .ctl_i(ctl_v),
        .v_i(v_w), .k_i(k_w), .ctl_o(ctl_p), .p_o(p_w)
    );

    wino_out_xform #(.W(DW), .PW(PW), .KFRAC(KFRAC)) u_outx (
        .clk(clk), .rst_n(rst_n), .en(advance), .ctl_i(ctl_p),
        .p_i(p_w), .ctl_o(ctl_y), .y_o(y_w)
    );

    wino_accum #(.W(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(advance), .ctl_i(ctl_y),
        .y_i(y_w), .out_valid(out_valid), .out_tile(out_tile)
    );
endmodule

// File: rtl/wino_conv_pe_chk.sv
module wino_conv_pe_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_ready,
    input logic [4*DW-1:0] out_tile
);
    logic [3:0] inflight;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight
                        + 4'(in_valid && in_ready && in_last)
                        - 4'(out_valid && out_ready);
        end
    end

    p_ready_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tile)));

    p_emit_needs_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != 4'd0));

    p_inflight_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 4'd7);
endmodule

bind wino_conv_pe wino_conv_pe_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_tile(out_tile)
);

// File: tb/sim_wino_conv_pe.sv
module sim_wino_conv_pe;
    localparam int DW = 32;
    typedef longint arr16_t [16];
    typedef longint arr9_t [9];
    typedef longint arr4_t [4];

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_first, in_last, out_valid, out_ready;
    logic [16*DW-1:0] in_tile, in_kern;
    logic [4*DW-1:0]  out_tile;

    always #5 clk = ~clk;

    wino_conv_pe #(.DW(DW), .KFRAC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tile(in_tile), .in_kern(in_kern), .in_first(in_first),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_tile(out_tile)
    );

    int checks = 0, errors = 0;
    int cyc = 0, rdy_pct = 100;
    int n_pushed = 0, n_got = 0, vld_seen = 0;
    int first_seen = 0, acc_cyc = 0, tries = 0;
    bit prev_stall = 0, prev_vld = 0, done = 0;
    logic [4*DW-1:0] prev_tile = '0;
    logic [4*DW-1:0] expq [$];
    arr4_t exp_acc = '{default: 0};
    string cur_tag = "R2";

    task automatic chk(input bit ok, input string tag, input logic [4*DW-1:0] act,
                       input logic [4*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic arr16_t kxf(input arr9_t g);
        longint gs [4][3];
        longint t [4][3];
        arr16_t u;
        gs = '{'{2, 0, 0}, '{1, 1, 1}, '{1, -1, 1}, '{0, 0, 2}};
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 3; j++) begin
                t[i][j] = 0;
                for (int a = 0; a < 3; a++) t[i][j] += gs[i][a] * g[a*3+j];
            end
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 4; k++) begin
                u[i*4+k] = 0;
                for (int b = 0; b < 3; b++) u[i*4+k] += t[i][b] * gs[k][b];
            end
        return u;
    endfunction

    function automatic arr4_t conv(input arr16_t d, input arr9_t g);
        arr4_t y;
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++) begin
                y[i*2+j] = 0;
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 3; b++)
                        y[i*2+j] += d[(i+a)*4+j+b] * g[a*3+b];
            end
        return y;
    endfunction

    function automatic logic [16*DW-1:0] pack16(input arr16_t x);
        logic [16*DW-1:0] v;
        for (int i = 0; i < 16; i++) v[i*DW +: DW] = x[i][DW-1:0];
        return v;
    endfunction

    function automatic logic [4*DW-1:0] pack4(input arr4_t x);
        logic [4*DW-1:0] v;
        for (int i = 0; i < 4; i++) v[i*DW +: DW] = x[i][DW-1:0];
        return v;
    endfunction

    task automatic step(input logic v, input logic [16*DW-1:0] d, input logic [16*DW-1:0] k,
                        input logic f, input logic l, output logic acc);
        @(negedge clk);
        in_valid = v; in_tile = d; in_kern = k; in_first = f; in_last = l;
        out_ready = (($urandom % 100) < rdy_pct);
        #1;
        if (prev_stall) begin
            chk(out_valid && (out_tile == prev_tile), "R6 output held during stall",
                out_tile, prev_tile);
        end
        if (out_valid && !out_ready) chk(!in_ready, "R6 in_ready low in stall",
                                         {127'b0, in_ready}, '0);
        if (out_valid) vld_seen++;
        if (out_valid && !prev_vld) first_seen = cyc;
        if (out_valid && out_ready) begin
            n_got++;
            if (expq.size() == 0) chk(0, "R7 unexpected output tile", out_tile, '0);
            else begin
                logic [4*DW-1:0] e;
                e = expq.pop_front();
                chk(out_tile == e, cur_tag, out_tile, e);
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_tile  = out_tile;
        prev_vld   = out_valid;
        acc = v && in_ready;
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        logic a;
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, 1'b0, a);
    endtask

    task automatic send(input arr16_t d, input arr9_t g, input bit f, input bit l);
        logic a;
        arr4_t y;
        y = conv(d, g);
        tries = 0;
        do begin
            step(1'b1, pack16(d), pack16(kxf(g)), f, l, a);
            tries++;
        end while (!a);
        acc_cyc = cyc;
        for (int i = 0; i < 4; i++) exp_acc[i] = (f ? 0 : exp_acc[i]) + y[i];
        if (l) begin
            expq.push_back(pack4(exp_acc));
            n_pushed++;
        end
    endtask

    task automatic rnd_tile(output arr16_t d, output arr9_t g, input int dr, input int gr);
        for (int i = 0; i < 16; i++) d[i] = longint'($urandom_range(2*dr - 1)) - dr;
        for (int i = 0; i < 9; i++)  g[i] = longint'($urandom_range(2*gr - 1)) - gr;
    endtask

    initial begin
        arr16_t d;
        arr9_t g;
        int nch, vs;
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 0; in_first = 0; in_last = 0; out_ready = 1;
        in_tile = '0; in_kern = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", {127'b0, out_valid}, '0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", {127'b0, in_ready}, 128'd1);

        // R4 latency on empty pipeline, R2 value
        rdy_pct = 100; cur_tag = "R2 single-channel tile";
        rnd_tile(d, g, 2048, 128);
        send(d, g, 1, 1);
        idle(10);
        chk(first_seen - acc_cyc == 6, "R4 latency edges after accept",
            128'(first_seen - acc_cyc), 128'd6);

        // R2 several single-channel tiles, including identity filter
        g = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
        for (int i = 0; i < 16; i++) d[i] = i * 7 - 50;
        send(d, g, 1, 1);
        for (int t = 0; t < 10; t++) begin
            rnd_tile(d, g, 2048, 128);
            send(d, g, 1, 1);
        end
        idle(10);

        // R5 back-to-back acceptance with output always ready
        for (int t = 0; t < 20; t++) begin
            rnd_tile(d, g, 2048, 128);
            send(d, g, 1, 1);
            chk(tries == 1, "R5 tile accepted in first cycle", 128'(tries), 128'd1);
        end
        idle(10);

        // R8 non-final channel emits nothing
        cur_tag = "R8 accumulation unaffected by gaps";
        vs = vld_seen;
        rnd_tile(d, g, 2048, 128);
        send(d, g, 1, 0);
        idle(12);
        chk(vld_seen == vs, "R8 no output for non-last tile", 128'(vld_seen), 128'(vs));
        rnd_tile(d, g, 2048, 128);
        send(d, g, 0, 1);
        idle(10);

        // R3 wraparound with large values over three channels
        cur_tag = "R3 wrapped accumulation";
        for (int ch = 0; ch < 3; ch++) begin
            rnd_tile(d, g, 1 << 20, 1 << 10);
            send(d, g, ch == 0, ch == 2);
        end
        idle(10);

        // R3 R6 R7 random groups with gaps and stalls
        cur_tag = "R3 multi-channel tile";
        rdy_pct = 60;
        for (int grp = 0; grp < 60; grp++) begin
            nch = 1 + ($urandom % 4);
            for (int ch = 0; ch < nch; ch++) begin
                idle($urandom % 3);
                rnd_tile(d, g, 2048, 128);
                send(d, g, ch == 0, ch == nch - 1);
            end
        end
        rdy_pct = 100;
        idle(20);
        chk(n_got == n_pushed, "R7 output count equals last-tile count",
            128'(n_got), 128'(n_pushed));
        chk(expq.size() == 0, "R7 no pending expected tiles", 128'(expq.size()), '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule